// File: doc/BRIEF.md
# PWM Edge Soft-Start Modulator

This block supplies the rising-edge and falling-edge timing values for a bank of PWM outputs during the soft start of an unregulated channel. At a start pulse, each modulated edge is pushed away from its programmed preset by a variation value. After that, it walks back toward the preset in fixed steps of 40 ns. One step is taken every 1, 2, 4 or 8 switching cycles. The PWM counter that uses these values sits outside the block. That counter marks each switching period with a one-cycle end-of-cycle strobe.

There are two variation values, and both are taken from the presets at the moment of start. Outputs with even index (0, 2, 4, 6) use the distance between output 0's falling and rising presets. Outputs with odd index use the same distance measured on output 1. Polarity is chosen per edge. A positive edge starts late, at preset plus variation, and moves earlier. A negative edge starts early, at preset minus variation, and moves later. When every offset has reached zero, a done flag is raised.

Top module: `pwm_edge_softstart`

## Requirements
- R1: While reset is asserted and after it is released, all offsets are zero, every edge output equals its preset, and done is 1.
- R2: Two variation values are captured at start. var_a = |fall_preset[0] - rise_preset[0]| applies to outputs 0, 2, 4 and 6. var_b = |fall_preset[1] - rise_preset[1]| applies to outputs 1, 3, 5 and 7. Edge times are 10-bit values at 5 ns per LSB.
- R3: In the cycle after start, a modulated edge whose polarity bit is 1 outputs preset + variation, saturated at 1023.
- R4: In the cycle after start, a modulated edge whose polarity bit is 0 outputs preset - variation, saturated at 0.
- R5: An edge whose modulation-enable bit is 0 outputs its preset at all times.
- R6: The offset of each modulated edge drops by 8 LSB (40 ns) once per 2^rate_sel end-of-cycle strobes. The rate_sel code maps 0→1, 1→2, 2→4 and 3→8 strobes. Between steps, the outputs hold.
- R7: A step that finds an offset below 8 LSB sets it to zero, so the edge lands exactly on its preset.
- R8: done is 0 while any offset is nonzero and 1 once all offsets are zero.
- R9: A start pulse during a ramp reloads every offset with its full variation and restarts the strobe count from zero.
- R10: When start and an end-of-cycle strobe arrive in the same cycle, start wins and no step is taken.
- R11: The rising and falling edges of one output are modulated independently, each with its own enable and polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle soft-start trigger |
| cycle_end | input | 1 | One-cycle strobe at the end of each switching cycle |
| rate_sel | input | 2 | Step interval code: 2^rate_sel strobes per step |
| rise_preset | input | 80 | Rising-edge presets, output k at bits [10k+9:10k] |
| fall_preset | input | 80 | Falling-edge presets, same packing |
| rise_mod | input | 8 | Rising-edge modulation enable per output |
| fall_mod | input | 8 | Falling-edge modulation enable per output |
| rise_pos | input | 8 | Rising-edge polarity per output, 1 = positive |
| fall_pos | input | 8 | Falling-edge polarity per output, 1 = positive |
| rise_time | output | 80 | Current rising-edge times |
| fall_time | output | 80 | Current falling-edge times |
| done | output | 1 | All modulated edges are at their presets |

## Verification
The bench builds the block with its default parameters: eight outputs, 10-bit edge times, and a 40 ns step at 5 ns resolution. With these values both variation groups are exercised by alternating outputs. Variations near 900 LSB drive the edges into saturation at both 0 and 1023. The 8 LSB step also produces non-multiple remainders such as 13 and 10, which test the final clamp. All four rate codes are swept, including the 8-strobe interval, so the strobe counter reaches its widest setting.

// File: rtl/pwm_ss_pkg.sv
package pwm_ss_pkg;

   // Per-edge modulation setup
   typedef struct packed {
      logic mod_en;   // edge takes part in the soft start
      logic pos;      // 1: starts late and moves earlier
   } ss_edge_cfg_t;

   // Edge selector used when the edge bank is generated
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } ss_edge_kind_e;

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cycle_end,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              step
);
   localparam int CNT_W = (1 << RATE_W) - 1;

   generate
      if (RATE_W < 1 || RATE_W > 3) begin : g_bad_rate
         $error("ss_step_timer: RATE_W must be 1..3");
      end
   endgenerate

   logic [CNT_W:0]   one_hot;
   logic [CNT_W:0]   lim_full;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      one_hot  = (CNT_W+1)'(1) << rate_sel;
      lim_full = one_hot - (CNT_W+1)'(1);
      lim      = lim_full[CNT_W-1:0];
   end

   // >= so that a rate change mid-ramp never strands the counter
   assign step = cycle_end && !start && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= '0;
      end else if (cycle_end) begin
         if (cnt >= lim) cnt <= '0;
         else            cnt <= cnt + 1'b1;
      end
   end

   AST_STEP_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cnt == '0);  // R6
   AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> cnt == '0);  // R9

endmodule

// File: rtl/ss_variation.sv
module ss_variation #(
   parameter int TW = 10
) (
   input  logic [TW-1:0] rise_ref,
   input  logic [TW-1:0] fall_ref,
   output logic [TW-1:0] variation
);
   always_comb begin
      if (fall_ref >= rise_ref) variation = fall_ref - rise_ref;
      else                      variation = rise_ref - fall_ref;
   end
endmodule

// File: rtl/ss_edge_unit.sv
module ss_edge_unit
   import pwm_ss_pkg::*;
#(
   parameter int TW       = 10,
   parameter int STEP_LSB = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         step,
   input  logic [TW-1:0] preset,
   input  logic [TW-1:0] variation,
   input  ss_edge_cfg_t cfg,
   output logic [TW-1:0] edge_time,
   output logic         at_preset
);
   localparam logic [TW-1:0] STEP_V = TW'(STEP_LSB);

   logic [TW-1:0] offset;
   logic [TW-1:0] load_val;
   logic [TW:0]   sum_w;
   logic [TW:0]   dif_w;

   assign load_val  = cfg.mod_en ? variation : '0;
   assign at_preset = (offset == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset <= '0;
      end else if (start) begin
         offset <= load_val;
      end else if (step) begin
         if (offset > STEP_V) offset <= offset - STEP_V;
         else                 offset <= '0;
      end
   end

   // saturating placement of the edge around its preset
   always_comb begin
      sum_w = {1'b0, preset} + {1'b0, offset};
      dif_w = {1'b0, preset} - {1'b0, offset};
      if (!cfg.mod_en || offset == '0) edge_time = preset;
      else if (cfg.pos)                edge_time = sum_w[TW] ? '1 : sum_w[TW-1:0];
      else                             edge_time = dif_w[TW] ? '0 : dif_w[TW-1:0];
   end

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> offset == $past(load_val));  // R9
   AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> offset <= $past(offset));  // R6
   AST_FINAL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && offset <= STEP_V) |=> offset == '0);  // R7
   AST_UNMOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cfg.mod_en) |=> at_preset);  // R5

endmodule

// File: rtl/pwm_edge_softstart.sv
module pwm_edge_softstart
   import pwm_ss_pkg::*;
#(
   parameter int NUM_OUT = 8,
   parameter int TW      = 10,
   parameter int RATE_W  = 2,
   parameter int STEP_NS = 40,
   parameter int LSB_NS  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  cycle_end,
   input  logic [RATE_W-1:0]     rate_sel,
   input  logic [NUM_OUT*TW-1:0] rise_preset,
   input  logic [NUM_OUT*TW-1:0] fall_preset,
   input  logic [NUM_OUT-1:0]    rise_mod,
   input  logic [NUM_OUT-1:0]    fall_mod,
   input  logic [NUM_OUT-1:0]    rise_pos,
   input  logic [NUM_OUT-1:0]    fall_pos,
   output logic [NUM_OUT*TW-1:0] rise_time,
   output logic [NUM_OUT*TW-1:0] fall_time,
   output logic                  done
);
   localparam int STEP_LSB = STEP_NS / LSB_NS;
   localparam int N_VAR    = 2;
   localparam int N_EDGE   = 2 * NUM_OUT;

   generate
      if (NUM_OUT < N_VAR) begin : g_bad_out
         $error("pwm_edge_softstart: NUM_OUT must be at least 2");
      end
      if (STEP_NS % LSB_NS != 0) begin : g_bad_step
         $error("pwm_edge_softstart: step must be a whole number of LSB");
      end
      if (STEP_LSB < 1 || STEP_LSB >= (1 << TW)) begin : g_bad_lsb
         $error("pwm_edge_softstart: step does not fit the edge width");
      end
   endgenerate

   logic              step;
   logic [TW-1:0]     var_grp [N_VAR];
   logic [N_EDGE-1:0] edge_idle;

   ss_step_timer #(.RATE_W(RATE_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cycle_end(cycle_end),
      .rate_sel (rate_sel),
      .step     (step)
   );

   // group g measures the spacing of output g
   for (genvar g = 0; g < N_VAR; g++) begin : g_var
      ss_variation #(.TW(TW)) i_var (
         .rise_ref (rise_preset[g*TW +: TW]),
         .fall_ref (fall_preset[g*TW +: TW]),
         .variation(var_grp[g])
      );
   end

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      for (genvar e = 0; e < 2; e++) begin : g_edge
         localparam ss_edge_kind_e KIND = ss_edge_kind_e'(e);
         ss_edge_cfg_t  cfg;
         logic [TW-1:0] pre;
         logic [TW-1:0] tim;

         if (KIND == EDGE_RISE) begin : g_r
            assign cfg = '{mod_en: rise_mod[k], pos: rise_pos[k]};
            assign pre = rise_preset[k*TW +: TW];
            assign rise_time[k*TW +: TW] = tim;
         end else begin : g_f
            assign cfg = '{mod_en: fall_mod[k], pos: fall_pos[k]};
            assign pre = fall_preset[k*TW +: TW];
            assign fall_time[k*TW +: TW] = tim;
         end

         ss_edge_unit #(.TW(TW), .STEP_LSB(STEP_LSB)) i_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start),
            .step     (step),
            .preset   (pre),
            .variation(var_grp[k % N_VAR]),
            .cfg      (cfg),
            .edge_time(tim),
            .at_preset(edge_idle[2*k+e])
         );
      end

      AST_DONE_RISE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> rise_time[k*TW +: TW] == rise_preset[k*TW +: TW]);  // R8
      AST_DONE_FALL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> fall_time[k*TW +: TW] == fall_preset[k*TW +: TW]);  // R8
   end

   assign done = &edge_idle;

   AST_STEP_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cycle_end && !start));  // R10

endmodule

// File: tb/test_pwm_edge_softstart.sv
`timescale 1ns/1ps
module test_pwm_edge_softstart;
   localparam int NO = 8;
   localparam int TW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cycle_end = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic [NO*TW-1:0] rise_preset = '0, fall_preset = '0;
   logic [NO-1:0] rise_mod = '0, fall_mod = '0, rise_pos = '0, fall_pos = '0;
   logic [NO*TW-1:0] rise_time, fall_time;
   logic done;

   int n_chk = 0;
   int n_fail = 0;
   int var_a, var_b;

   always #2.5 clk = ~clk;

   pwm_edge_softstart i_pwm_edge_softstart (
      .clk(clk), .rst_n(rst_n), .start(start), .cycle_end(cycle_end),
      .rate_sel(rate_sel), .rise_preset(rise_preset), .fall_preset(fall_preset),
      .rise_mod(rise_mod), .fall_mod(fall_mod), .rise_pos(rise_pos),
      .fall_pos(fall_pos), .rise_time(rise_time), .fall_time(fall_time),
      .done(done)
   );

   typedef struct packed {
      logic [9:0] base_r;
      logic [9:0] base_f;
      logic [9:0] extra;
      logic [7:0] rmod;
      logic [7:0] fmod;
      logic [7:0] rpos;
      logic [7:0] fpos;
      logic [1:0] rate;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{10'd100, 10'd300, 10'd0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 2'd0},
      '{10'd50,  10'd60,  10'd3, 8'h0F, 8'hF0, 8'hAA, 8'h55, 2'd1},
      '{10'd400, 10'd200, 10'd5, 8'hFF, 8'hFF, 8'h00, 8'hFF, 2'd2},
      '{10'd5,   10'd900, 10'd0, 8'hFF, 8'hFF, 8'h00, 8'hFF, 2'd0},
      '{10'd20,  10'd44,  10'd0, 8'h33, 8'hCC, 8'h0F, 8'hF0, 2'd3},
      '{10'd10,  10'd30,  10'd0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0}
   };

   function automatic int absd(int a, int b);
      return (a > b) ? a - b : b - a;
   endfunction

   // expected edge time from the requirements
   function automatic int exp_edge(int pre, int vr, bit en, bit pos, int steps);
      int ofs;
      if (!en) return pre;
      ofs = vr - 8 * steps;
      if (ofs < 0) ofs = 0;
      if (pos) return (pre + ofs > 1023) ? 1023 : pre + ofs;
      return (pre - ofs < 0) ? 0 : pre - ofs;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic apply_vec(vec_t v);
      for (int k = 0; k < NO; k++) begin
         rise_preset[k*TW +: TW] = TW'(int'(v.base_r) + 16*k);
         fall_preset[k*TW +: TW] = TW'(int'(v.base_f) + 16*k + ((k % 2 == 1) ? int'(v.extra) : 0));
      end
      rise_mod = v.rmod; fall_mod = v.fmod;
      rise_pos = v.rpos; fall_pos = v.fpos;
      rate_sel = v.rate;
      // R2: group values from outputs 0 and 1
      var_a = absd(int'(fall_preset[0 +: TW]), int'(rise_preset[0 +: TW]));
      var_b = absd(int'(fall_preset[TW +: TW]), int'(rise_preset[TW +: TW]));
   endtask

   function automatic string tag_of(bit en, bit pos, int vr, int steps);
      if (!en) return "R5";
      if (steps == 0) return pos ? "R3" : "R4";
      if (vr > 8 * (steps - 1) && vr < 8 * steps) return "R7";
      return "R6";
   endfunction

   // compare all edges and done against the model after 'steps' steps
   task automatic check_all(int steps, string ctx);
      bit all_home = 1'b1;
      for (int k = 0; k < NO; k++) begin
         int vr = (k % 2 == 0) ? var_a : var_b;
         int rp = int'(rise_preset[k*TW +: TW]);
         int fp = int'(fall_preset[k*TW +: TW]);
         // R11: rise and fall use their own enable and polarity
         chk({tag_of(rise_mod[k], rise_pos[k], vr, steps), " rise ", ctx},
             int'(rise_time[k*TW +: TW]), exp_edge(rp, vr, rise_mod[k], rise_pos[k], steps));
         chk({tag_of(fall_mod[k], fall_pos[k], vr, steps), " fall ", ctx},
             int'(fall_time[k*TW +: TW]), exp_edge(fp, vr, fall_mod[k], fall_pos[k], steps));
         if ((rise_mod[k] || fall_mod[k]) && vr > 8 * steps) all_home = 1'b0;
      end
      chk({"R8 done ", ctx}, int'(done), int'(all_home));
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic pulse_strobe();
      @(negedge clk) cycle_end = 1'b1;
      @(negedge clk) cycle_end = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      apply_vec(VECS[0]);
      repeat (3) @(negedge clk);
      check_all(1000, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all(1000, "R1 after reset");

      // table walk
      for (int i = 0; i < NV; i++) begin
         int mx, steps_end;
         apply_vec(VECS[i]);
         pulse_start();
         mx = (var_a > var_b) ? var_a : var_b;
         steps_end = (mx + 7) / 8 + 1;
         for (int n = 0; n <= (steps_end << VECS[i].rate); n++) begin
            check_all(n >> VECS[i].rate, $sformatf("vec %0d strobe %0d", i, n));
            pulse_strobe();
         end
      end

      // R9: restart mid-ramp reloads offsets and the strobe count
      apply_vec(VECS[0]);
      rate_sel = 2'd2;
      pulse_start();
      repeat (5) pulse_strobe();
      check_all(1, "R6 mid ramp");
      repeat (3) pulse_strobe();
      pulse_start();
      check_all(0, "R9 reload");
      repeat (3) pulse_strobe();
      check_all(0, "R9 count restarted");
      pulse_strobe();
      check_all(1, "R9 first step after restart");

      // R10: start and strobe together, start wins
      rate_sel = 2'd0;
      repeat (3) pulse_strobe();
      @(negedge clk) begin start = 1'b1; cycle_end = 1'b1; end
      @(negedge clk) begin start = 1'b0; cycle_end = 1'b0; end
      check_all(0, "R10 start priority");
      pulse_strobe();
      check_all(1, "R10 next strobe steps");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule